// File: doc/BRIEF.md
# Clocked Local-Bus Register Slave

This block is the slave end of a clocked host local bus, in front of a small register file that is switched between banks. The host opens each transfer with an address phase: the address, an active-low qualifier and four active-low byte enables are presented while an address strobe is low. A cycle strobe then marks the transfer. On the first clock edge that sees the cycle strobe low, the slave samples the direction line. It completes the transfer with a ready pulse that lasts one clock, then waits until the host answers on the ready-return line.

Writes complete in the clock right after the cycle strobe is seen. Reads spend one extra clock fetching the addressed bytes. Read data stays on the bus until the host returns ready. Any mix of the four byte lanes can be selected. The 16-byte window decodes as bank storage at offsets 0 to 13. Offsets 14 and 15 form a bank-select pair that is visible in every bank, and the low bits of offset 14 choose the bank.

Top module: `lbus_reg_slave`

## Requirements
- R1: While addrStrobeN is low and no transfer is in progress, the address, qualN and byteEnN pass straight through to the decode. The values present at the last clock edge with addrStrobeN low are held for the transfer that follows.
- R2: A decode is valid only when qualN is low and addrIn[ADDR_W-1:4] equals TAG. claimN is low during the address phase of a valid decode and for the rest of that transfer. It is high otherwise.
- R3: At the first rising edge that sees cycleN low with a valid decode, wrNrd is sampled (1 = write, 0 = read). For a write, readyN is low in the next clock, and the selected lanes of wrData are stored at the end of that clock.
- R4: readyN is low for exactly one clock per transfer.
- R5: A read keeps readyN high for one fetch clock after the edge that starts it. readyN is then low for one clock, with the addressed bytes on dataOut and laneOe set.
- R6: Read data and laneOe stay unchanged until the first rising edge that samples readyRetN low (the ready clock included). After that edge laneOe is 0. A write also waits for readyRetN low before a new transfer can start.
- R7: byteEnN[i] low selects byte lane i (dataOut/wrData bits 8i+7:8i), which holds register offset 4*dword+i. On reads, unselected lanes have laneOe low and read as 0. On writes, unselected lanes leave their registers unchanged.
- R8: A write to dword 3 with all four lanes selected (byteEnN = 0000) updates only offsets 14 and 15. Offsets 12 and 13 keep their values.
- R9: Offsets 0 to 13 address the bank given by offset 14 bits [BANK_BITS-1:0]. Offsets 14 and 15 are shared by all banks.
- R10: An address strobe during a transfer in progress is ignored and the held address stays in use. overlapErr goes high in the clock after each such clock.
- R11: After reset, readyN and claimN are high, laneOe and overlapErr are 0, and all registers read 0 (bank 0 selected).
- R12: A cycle without a valid decode gets no response: readyN stays high and claimN stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addrIn | input | ADDR_W-2 | Dword address bits [ADDR_W-1:2] |
| addrStrobeN | input | 1 | Address strobe, active low |
| qualN | input | 1 | Address qualifier, active low |
| byteEnN | input | 4 | Byte lane enables, active low |
| cycleN | input | 1 | Cycle strobe, active low |
| wrNrd | input | 1 | Direction: 1 write, 0 read |
| readyRetN | input | 1 | Ready return from host, active low |
| wrData | input | 32 | Write data |
| dataOut | output | 32 | Read data (0 on undriven lanes) |
| laneOe | output | 4 | Per-lane read drive enable |
| readyN | output | 1 | Transfer ready, active low |
| claimN | output | 1 | Cycle claim, active low |
| overlapErr | output | 1 | Address strobe seen during a transfer |

## Verification
The bench stretches ready-return over several clocks. A design that releases read data early would show laneOe or dataOut changing before the return edge. It writes a full dword to offsets 12 to 15. A design that ignored the bank-select rule would change offsets 12 and 13, and a later narrow read would expose that. It raises the address strobe during a read wait, then starts a cycle with no new address phase. A design that latched the stray address would read the wrong dword or miss the overlap flag. Random lane masks, bank switches and return delays are checked against a byte model, which catches lane steering errors, extra fetch clocks and ready pulses that are too long.

// File: rtl/lbus_pkg.sv
package lbus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_READY = 2'd2,
    ST_WAIT  = 2'd3
  } busState_t;

  typedef struct packed {
    logic rdLoad;
    logic wrCommit;
    logic drive;
  } strobe_t;
endpackage

// File: rtl/lbus_ctrl.sv
module lbus_ctrl
  import lbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-5:0] TAG = 12'h030
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:2] addrIn,
  input  logic              addrStrobeN,
  input  logic              qualN,
  input  logic [3:0]        byteEnN,
  input  logic              cycleN,
  input  logic              wrNrd,
  input  logic              readyRetN,
  output strobe_t           stb,
  output logic [1:0]        dwIdx,
  output logic [3:0]        laneSel,
  output logic              readyN,
  output logic              claimN,
  output logic              overlapErr
);
  busState_t state;
  logic [ADDR_W-1:2] addrQ;
  logic [3:0] beQ;
  logic qualQ, isWr, armed, errQ;
  logic idle, live, effQual, hit, start;
  logic [ADDR_W-1:2] effAddr;
  logic [3:0] effBe;

  assign idle    = (state == ST_IDLE);
  assign live    = !addrStrobeN && idle;
  assign effAddr = live ? addrIn  : addrQ;
  assign effBe   = live ? byteEnN : beQ;
  assign effQual = live ? qualN   : qualQ;
  assign hit     = !effQual && (effAddr[ADDR_W-1:4] == TAG);
  assign start   = idle && !cycleN && hit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      beQ   <= 4'hF;
      qualQ <= 1'b1;
    end else if (live) begin
      addrQ <= addrIn;
      beQ   <= byteEnN;
      qualQ <= qualN;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      isWr  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          isWr  <= wrNrd;
          state <= wrNrd ? ST_READY : ST_FETCH;
        end
        ST_FETCH: state <= ST_READY;
        ST_READY: state <= readyRetN ? ST_WAIT : ST_IDLE;
        ST_WAIT:  if (!readyRetN) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b0;
      errQ  <= 1'b0;
    end else begin
      errQ <= !addrStrobeN && !idle;
      if (start)     armed <= 1'b0;
      else if (live) armed <= 1'b1;
    end
  end

  always_comb begin
    stb.rdLoad   = (state == ST_FETCH);
    stb.wrCommit = (state == ST_READY) && isWr;
    stb.drive    = ((state == ST_READY) || (state == ST_WAIT)) && !isWr;
  end

  assign dwIdx      = effAddr[3:2];
  assign laneSel    = ~effBe;
  assign readyN     = (state != ST_READY);
  assign claimN     = !(hit && (live || armed || !idle));
  assign overlapErr = errQ;
endmodule

// File: rtl/lbus_regs.sv
module lbus_regs
  import lbus_pkg::*;
#(
  parameter int BANK_BITS = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     stb,
  input  logic [1:0]  dwIdx,
  input  logic [3:0]  laneSel,
  input  logic [31:0] wrData,
  output logic [31:0] dataOut,
  output logic [3:0]  laneOe
);
  localparam int NUM_BANKS = 1 << BANK_BITS;
  localparam int WIN_BYTES = 16;
  localparam int SEL_OFS   = WIN_BYTES - 2;
  localparam int LAST_DW   = WIN_BYTES / 4 - 1;

  logic [7:0] bankMem [NUM_BANKS][SEL_OFS];
  logic [7:0] selLo, selHi;
  logic [BANK_BITS-1:0] bank;
  logic [31:0] rdData;
  logic [7:0] rdByte [4];
  logic [3:0] laneOfs [4];
  logic [3:0] laneWr;
  logic fullSelDw;

  assign bank      = selLo[BANK_BITS-1:0];
  assign fullSelDw = (dwIdx == 2'(LAST_DW)) && (laneSel == 4'hF);

  for (genvar l = 0; l < 4; l++) begin : g_lane
    assign laneOfs[l] = {dwIdx, 2'(l)};
    if (l < 2) begin : g_lowHalf
      assign laneWr[l] = stb.wrCommit && laneSel[l] && !fullSelDw;
    end else begin : g_highHalf
      assign laneWr[l] = stb.wrCommit && laneSel[l];
    end

    always_comb begin
      rdByte[l] = 8'h00;
      if (laneOfs[l] == 4'(SEL_OFS)) rdByte[l] = selLo;
      else if (laneOfs[l] == 4'(SEL_OFS + 1)) rdByte[l] = selHi;
      else begin
        for (int b = 0; b < NUM_BANKS; b++)
          for (int o = 0; o < SEL_OFS; o++)
            if (b == int'(bank) && o == int'(laneOfs[l])) rdByte[l] = bankMem[b][o];
      end
    end

    assign laneOe[l]        = stb.drive && laneSel[l];
    assign dataOut[8*l +: 8] = laneOe[l] ? rdData[8*l +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selLo <= '0;
      selHi <= '0;
      for (int b = 0; b < NUM_BANKS; b++)
        for (int o = 0; o < SEL_OFS; o++) bankMem[b][o] <= '0;
    end else begin
      for (int l = 0; l < 4; l++) begin
        if (laneWr[l]) begin
          if (laneOfs[l] == 4'(SEL_OFS)) selLo <= wrData[8*l +: 8];
          else if (laneOfs[l] == 4'(SEL_OFS + 1)) selHi <= wrData[8*l +: 8];
          else begin
            for (int b = 0; b < NUM_BANKS; b++)
              for (int o = 0; o < SEL_OFS; o++)
                if (b == int'(bank) && o == int'(laneOfs[l]))
                  bankMem[b][o] <= wrData[8*l +: 8];
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if (stb.rdLoad) rdData <= {rdByte[3], rdByte[2], rdByte[1], rdByte[0]};
  end
endmodule

// File: rtl/lbus_reg_slave.sv
module lbus_reg_slave
  import lbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BANK_BITS = 3,
  parameter logic [ADDR_W-5:0] TAG = 12'h030
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:2] addrIn,
  input  logic              addrStrobeN,
  input  logic              qualN,
  input  logic [3:0]        byteEnN,
  input  logic              cycleN,
  input  logic              wrNrd,
  input  logic              readyRetN,
  input  logic [31:0]       wrData,
  output logic [31:0]       dataOut,
  output logic [3:0]        laneOe,
  output logic              readyN,
  output logic              claimN,
  output logic              overlapErr
);
  strobe_t stb;
  logic [1:0] dwIdx;
  logic [3:0] laneSel;

  lbus_ctrl #(.ADDR_W(ADDR_W), .TAG(TAG)) u_ctrl (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .addrStrobeN(addrStrobeN),
    .qualN(qualN), .byteEnN(byteEnN), .cycleN(cycleN), .wrNrd(wrNrd),
    .readyRetN(readyRetN), .stb(stb), .dwIdx(dwIdx), .laneSel(laneSel),
    .readyN(readyN), .claimN(claimN), .overlapErr(overlapErr)
  );

  lbus_regs #(.BANK_BITS(BANK_BITS)) u_regs (
    .clk(clk), .rstN(rstN), .stb(stb), .dwIdx(dwIdx), .laneSel(laneSel),
    .wrData(wrData), .dataOut(dataOut), .laneOe(laneOe)
  );
endmodule

// File: rtl/lbus_reg_slave_chk.sv
module lbus_reg_slave_chk (
  input logic        clk,
  input logic        rstN,
  input logic        addrStrobeN,
  input logic        readyRetN,
  input logic [31:0] dataOut,
  input logic [3:0]  laneOe,
  input logic        readyN,
  input logic        claimN,
  input logic        overlapErr
);
  a_r4_ready_single: assert property (@(posedge clk) disable iff (!rstN)
    !readyN |=> readyN);

  a_r6_hold_until_return: assert property (@(posedge clk) disable iff (!rstN)
    ((|laneOe) && readyRetN) |=> ($stable(laneOe) && $stable(dataOut)));

  a_r6_release_on_return: assert property (@(posedge clk) disable iff (!rstN)
    ((|laneOe) && !readyRetN) |=> (laneOe == 4'h0));

  a_r5_drive_opens_with_ready: assert property (@(posedge clk) disable iff (!rstN)
    $rose(|laneOe) |-> !readyN);

  a_r2_claim_while_ready: assert property (@(posedge clk) disable iff (!rstN)
    !readyN |-> !claimN);

  a_r10_err_follows_strobe: assert property (@(posedge clk) disable iff (!rstN)
    overlapErr |-> $past(!addrStrobeN));
endmodule

bind lbus_reg_slave lbus_reg_slave_chk u_chk (
  .clk(clk), .rstN(rstN), .addrStrobeN(addrStrobeN), .readyRetN(readyRetN),
  .dataOut(dataOut), .laneOe(laneOe), .readyN(readyN), .claimN(claimN),
  .overlapErr(overlapErr)
);

// File: tb/lbus_reg_slave_test.sv
module lbus_reg_slave_test;
  localparam logic [11:0] TAG = 12'h030;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:2] addrIn = '0;
  logic addrStrobeN = 1'b1, qualN = 1'b1, cycleN = 1'b1, wrNrd = 1'b1, readyRetN = 1'b1;
  logic [3:0] byteEnN = 4'hF;
  logic [31:0] wrData = '0;
  logic [31:0] dataOut;
  logic [3:0] laneOe;
  logic readyN, claimN, overlapErr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] mdl [8][14];
  logic [7:0] mSel [2];

  always #4 clk = ~clk;

  lbus_reg_slave uut (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .addrStrobeN(addrStrobeN),
    .qualN(qualN), .byteEnN(byteEnN), .cycleN(cycleN), .wrNrd(wrNrd),
    .readyRetN(readyRetN), .wrData(wrData), .dataOut(dataOut), .laneOe(laneOe),
    .readyN(readyN), .claimN(claimN), .overlapErr(overlapErr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] modelByte(input int ofs);
    if (ofs >= 14) return mSel[ofs-14];
    return mdl[mSel[0][2:0]][ofs];
  endfunction

  function automatic logic [31:0] expRead(input int idx, input logic [3:0] lanes);
    logic [31:0] v = '0;
    for (int l = 0; l < 4; l++) if (lanes[l]) v[8*l +: 8] = modelByte(idx*4 + l);
    return v;
  endfunction

  task automatic modelWrite(input int idx, input logic [3:0] lanes, input logic [31:0] d);
    int bnk = int'(mSel[0][2:0]);
    for (int l = 0; l < 4; l++) begin
      int ofs = idx*4 + l;
      if (!lanes[l]) continue;
      if (idx == 3 && lanes == 4'hF && l < 2) continue;
      if (ofs >= 14) mSel[ofs-14] = d[8*l +: 8];
      else mdl[bnk][ofs] = d[8*l +: 8];
    end
  endtask

  task automatic addrPhase(input int idx, input logic [3:0] lanes, input logic q, input logic [11:0] tg, input bit expClaim);
    @(negedge clk);
    addrStrobeN = 1'b0; addrIn = {tg, 2'(idx)}; byteEnN = ~lanes; qualN = q;
    #2;
    chk(claimN == !expClaim, "R2 claim in address phase", 32'(claimN), 32'(!expClaim));
    @(negedge clk);
    addrStrobeN = 1'b1;
    addrIn = $urandom; byteEnN = $urandom; qualN = $urandom;
  endtask

  task automatic finishReturn(input int delay);
    if (delay > 0) begin
      for (int k = 1; k < delay; k++) @(negedge clk);
      readyRetN = 1'b0;
      @(negedge clk);
    end
    readyRetN = 1'b1;
  endtask

  task automatic doWrite(input int idx, input logic [3:0] lanes, input logic [31:0] d, input int delay);
    addrPhase(idx, lanes, 1'b0, TAG, 1'b1);
    cycleN = 1'b0; wrNrd = 1'b1;
    @(negedge clk);
    chk(readyN == 1'b0, "R3 write ready in clock after cycle edge", 32'(readyN), 0);
    cycleN = 1'b1; wrNrd = $urandom; wrData = d;
    readyRetN = (delay == 0) ? 1'b0 : 1'b1;
    @(negedge clk);
    chk(readyN == 1'b1, "R4 ready lasts one clock (write)", 32'(readyN), 1);
    wrData = $urandom;
    modelWrite(idx, lanes, d);
    finishReturn(delay);
  endtask

  task automatic doRead(input int idx, input logic [3:0] lanes, input int delay, input bit withAddr, input string req);
    logic [31:0] exp;
    if (withAddr) addrPhase(idx, lanes, 1'b0, TAG, 1'b1);
    else @(negedge clk);
    cycleN = 1'b0; wrNrd = 1'b0;
    @(negedge clk);
    chk(readyN == 1'b1 && laneOe == 4'h0, "R5 fetch clock before ready", {laneOe, 27'd0, readyN}, 32'h1);
    cycleN = 1'b1;
    @(negedge clk);
    exp = expRead(idx, lanes);
    chk(readyN == 1'b0, "R5 read ready after fetch clock", 32'(readyN), 0);
    chk(laneOe == lanes, "R7 lane drive matches enables", 32'(laneOe), 32'(lanes));
    chk(dataOut == exp, req, dataOut, exp);
    readyRetN = (delay == 0) ? 1'b0 : 1'b1;
    @(negedge clk);
    if (delay == 0) begin
      chk(laneOe == 4'h0, "R6 release after return", 32'(laneOe), 0);
      readyRetN = 1'b1;
    end else begin
      chk(laneOe == lanes && dataOut == exp && readyN, "R6 data held while return high", dataOut, exp);
      for (int k = 1; k < delay; k++) @(negedge clk);
      readyRetN = 1'b0;
      @(negedge clk);
      chk(laneOe == 4'h0, "R6 release after late return", 32'(laneOe), 0);
      readyRetN = 1'b1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] pats [7];
    pats = '{4'hF, 4'h3, 4'hC, 4'h1, 4'h2, 4'h4, 4'h8};
    void'($urandom(32'd20240611));
    for (int b = 0; b < 8; b++) for (int o = 0; o < 14; o++) mdl[b][o] = 8'h00;
    mSel[0] = 8'h00; mSel[1] = 8'h00;

    repeat (3) @(negedge clk);
    chk(readyN && claimN && laneOe == 0 && !overlapErr, "R11 reset outputs idle",
        {laneOe, 25'd0, readyN, claimN, overlapErr}, 32'h6);
    rstN = 1'b1;
    doRead(0, 4'hF, 0, 1, "R11 registers zero after reset");

    // R7 lane steering, R3 write commit
    doWrite(1, 4'hF, 32'h4433_2211, 0);
    doRead(1, 4'h4, 1, 1, "R7 single byte lane 2");
    doWrite(1, 4'h2, 32'hAAAA_99AA, 2);
    doRead(1, 4'hF, 0, 1, "R7 byte write leaves other lanes");
    doRead(1, 4'hC, 3, 1, "R7 high word read");

    // R8 dword write to bank-select dword
    doWrite(3, 4'h3, 32'h0000_BEEF, 0);
    doWrite(3, 4'hF, 32'h5A00_1234, 0);
    doRead(3, 4'hF, 0, 1, "R8 full dword write spares offsets 12-13");

    // R9 banks
    doWrite(0, 4'hF, 32'hC0DE_0000, 0);
    doWrite(3, 4'h4, 32'h0005_0000, 0);
    doRead(0, 4'hF, 0, 1, "R9 other bank starts at zero");
    doWrite(0, 4'hF, 32'h0BAD_F00D, 1);
    doWrite(3, 4'h4, 32'h0000_0000, 0);
    doRead(0, 4'hF, 0, 1, "R9 bank 0 contents kept");
    doRead(3, 4'hC, 0, 1, "R9 select pair shared");

    // R12 qualifier high / tag mismatch: no response
    for (int t = 0; t < 2; t++) begin
      addrPhase(0, 4'hF, (t == 0), (t == 0) ? TAG : 12'h031, 1'b0);
      cycleN = 1'b0; wrNrd = 1'b0;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        chk(readyN && claimN, "R12 no response without decode", {30'd0, readyN, claimN}, 32'h3);
      end
      cycleN = 1'b1;
    end

    // R10 strobe during wait, R1 held address reused
    addrPhase(2, 4'hF, 1'b0, TAG, 1'b1);
    cycleN = 1'b0; wrNrd = 1'b0;
    @(negedge clk); cycleN = 1'b1;
    @(negedge clk); readyRetN = 1'b1;
    @(negedge clk);
    addrStrobeN = 1'b0; addrIn = {TAG, 2'd0}; byteEnN = 4'h0; qualN = 1'b0;
    @(negedge clk);
    chk(overlapErr == 1'b1, "R10 overlap flagged", 32'(overlapErr), 1);
    chk(dataOut == expRead(2, 4'hF), "R10 held data unchanged", dataOut, expRead(2, 4'hF));
    addrStrobeN = 1'b1; readyRetN = 1'b0;
    @(negedge clk);
    readyRetN = 1'b1;
    chk(overlapErr == 1'b0 && laneOe == 0, "R10 flag clears after strobe", {laneOe, 27'd0, overlapErr}, 0);
    doWrite(2, 4'hF, 32'h1357_9BDF, 0);
    doRead(2, 4'hF, 0, 0, "R1 cycle without strobe uses held address");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int idx = $urandom % 4;
      logic [3:0] ln = pats[$urandom % 7];
      int dly = $urandom % 3;
      if ($urandom % 2) doWrite(idx, ln, $urandom, dly);
      else doRead(idx, ln, dly, 1, "R7 random read matches model");
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule